// File: doc/BRIEF.md
# Programmable Down-Counter Timer Core

This block is one timer channel for a peripheral subsystem. Software programs a reload value and a control byte through a simple word-addressed register port. A down-counter then decrements once per prescaled tick. The prescaler divides an external tick-enable input by 1, 16 or 256. The counter can run in three modes: free-running, where it wraps to the full 16-bit or 32-bit maximum; periodic, where it reloads from the programmed value; or one-shot, where it stops at zero. The count width is selectable at 16 or 32 bits.

Each time the count reaches zero, a sticky raw interrupt flag is set. The interrupt output is that flag gated by an enable bit in the control byte. Software clears the flag by writing the clear location. A second write location changes the reload value without disturbing the count that is in progress. The new value is picked up at the next natural reload. Read data is registered, so it appears one clock after the address is presented and reflects the state just before that edge.

Top module: `dctimer_core`

## Requirements
- R1: After synchronous reset the control byte reads 0x20 (interrupt enable set, timer stopped), the load and value locations read 0, and `irq` is low.
- R2: Word locations (byte address, low two address bits must be 0) are 0x00 reload value, 0x04 current count, 0x08 control, 0x0C flag clear, 0x10 raw flag (bit 0), 0x14 masked flag (bit 0), 0x18 background reload. Both 0x00 and 0x18 read back the reload value. A write to 0x04 is ignored. Every other address reads 0, and a write to it changes nothing.
- R3: A write to 0x00 stores the reload value and immediately reloads the counter with the current mode's reload value. When running at divide-by-1, the flag then sets exactly L clock edges after the write edge, for a reload value L.
- R4: The count changes only on a prescaled tick while enabled. On a tick at count 0 it reloads without setting the flag, so in periodic mode the flag is set every L+1 ticks.
- R5: A write to 0x18 updates the reload value but leaves the running count untouched. The new value is used at the next reload.
- R6: When both control bit 0 (one-shot) and control bit 6 (periodic) are clear, the timer is free-running. It reloads to 0xFFFF when control bit 1 is 0, or to 0xFFFFFFFF when bit 1 is 1, and ignores the stored reload value.
- R7: With control bit 1 clear, only the low 16 bits of the count and reload value are used, and 0x04 reads with bits 31:16 zero.
- R8: In one-shot mode (bit 0 set) the counter stops at 0 after expiry, and hardware clears control bit 7 (enable).
- R9: Control bits 3:2 select the tick divisor: 0 gives 1, 1 gives 16, 2 gives 256, and 3 gives 1. A control write restarts the divider. With the tick input low, nothing counts.
- R10: Expiry sets the raw flag, and the flag stays set until a write of any data to 0x0C. If expiry and a clear fall on the same edge, the flag ends up set.
- R11: `irq` is high exactly when the raw flag is set and control bit 5 is 1. It updates on the same edge as either of them. Location 0x14 reads 0 while bit 5 is clear.
- R12: A control write that leaves bit 7 set reloads the counter, so rewriting control on a running timer restarts its period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base count enable fed to the prescaler |
| we | input | 1 | Write strobe for the location at `addr` |
| addr | input | ADDR_W | Byte address of the register location |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the `addr` of the previous cycle |
| irq | output | 1 | Registered masked interrupt |

## Verification
The bench builds the core with its default parameters: an 8-bit address and divider shifts of 4 and 8. With these values, every defined location, unaligned and out-of-range addresses, and all four divisor codes can be reached in a short run. The periodic sweep covers reload values 1 to 6 at divide-by-1 and divide-by-16. For each case, the bench computes the first expiry delay (L × divisor) and the following period ((L+1) × divisor) arithmetically from a cycle counter. The free-running maxima, the 16-bit truncation, the same-edge clear/expiry collision and tick gating are each provoked on purpose.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int DATA_W = 32;

  // Control byte; packed MSB first so bit 7 is enable and bit 0 is one-shot.
  typedef struct packed {
    logic       enable;
    logic       periodic;
    logic       ie;
    logic       spare;
    logic [1:0] presc;
    logic       wide;
    logic       oneshot;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = 8'h20;

  typedef enum logic [2:0] {
    W_LOAD   = 3'd0,
    W_VALUE  = 3'd1,
    W_CTRL   = 3'd2,
    W_CLR    = 3'd3,
    W_RAW    = 3'd4,
    W_MIS    = 3'd5,
    W_BGLOAD = 3'd6,
    W_NONE   = 3'd7
  } word_e;

  // Value the counter is reloaded with in a given mode.
  function automatic logic [DATA_W-1:0] reload_of(ctrl_t c, logic [DATA_W-1:0] lim);
    logic [DATA_W-1:0] r;
    if (!c.periodic && !c.oneshot)
      r = c.wide ? {DATA_W{1'b1}} : {{(DATA_W-16){1'b0}}, 16'hFFFF};
    else
      r = c.wide ? lim : {{(DATA_W-16){1'b0}}, lim[15:0]};
    return r;
  endfunction

endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int SH_MID = 4,
  parameter int SH_MAX = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] sel,
  input  logic       restart,
  output logic       ptick
);
  localparam logic [SH_MAX-1:0] MID_M1 = {SH_MAX{1'b1}} >> (SH_MAX - SH_MID);
  localparam logic [SH_MAX-1:0] MAX_M1 = {SH_MAX{1'b1}};

  logic [SH_MAX-1:0] cnt_q;
  logic [SH_MAX-1:0] div_m1;

  always_comb begin
    unique case (sel)
      2'd1:    div_m1 = MID_M1;
      2'd2:    div_m1 = MAX_M1;
      default: div_m1 = '0;
    endcase
  end

  assign ptick = tick && !restart && (cnt_q >= div_m1);

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= ptick ? '0 : cnt_q + 1'b1;
  end

  // R9: the divider is frozen while the base tick is low
  p_idle_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt_q));

  p_no_tick_without_base_r9: assert property (@(posedge clk) disable iff (rst)
    !tick |-> !ptick);

endmodule

// File: rtl/dct_counter.sv
module dct_counter
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ptick,
  input  ctrl_t             ctrl_q,
  input  logic [DATA_W-1:0] limit_q,
  input  ctrl_t             ctrl_n,
  input  logic [DATA_W-1:0] limit_n,
  input  logic              force_reload,
  output logic [DATA_W-1:0] count_q,
  output logic              expire
);
  logic [DATA_W-1:0] cm;
  logic [DATA_W-1:0] count_n;
  logic              step;
  logic              free_run;

  assign cm       = ctrl_q.wide ? count_q : {{(DATA_W-16){1'b0}}, count_q[15:0]};
  assign step     = ptick && ctrl_q.enable && !force_reload;
  assign expire   = step && (cm == {{(DATA_W-1){1'b0}}, 1'b1});
  assign free_run = !ctrl_q.periodic && !ctrl_q.oneshot;

  always_comb begin
    count_n = count_q;
    if (force_reload)
      count_n = reload_of(ctrl_n, limit_n);
    else if (step) begin
      if (cm == '0) count_n = reload_of(ctrl_q, limit_q);
      else          count_n = cm - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_n;
  end

  // R4: count moves only on a tick or a forced reload
  p_hold_off_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (!ptick && !force_reload) |=> $stable(count_q));

  // R3: an expiry leaves the counter at zero
  p_zero_after_expire_r3: assert property (@(posedge clk) disable iff (rst)
    expire |=> (count_q == '0));

  // R6: 16-bit free-running wraps to the 16-bit maximum
  p_free_reload16_r6: assert property (@(posedge clk) disable iff (rst)
    (step && cm == '0 && free_run && !ctrl_q.wide) |=> (count_q[15:0] == 16'hFFFF));

endmodule

// File: rtl/dct_regs.sv
module dct_regs
  import dct_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  input  logic [DATA_W-1:0] count_q,
  output ctrl_t             ctrl_q,
  output ctrl_t             ctrl_n,
  output logic [DATA_W-1:0] limit_q,
  output logic [DATA_W-1:0] limit_n,
  output logic              force_reload,
  output logic              restart_ps,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] N_WORDS = IDX_W'(7);

  logic [IDX_W-1:0]  idx;
  logic              valid;
  word_e             sel;
  logic              wr_load, wr_ctrl, wr_clr, wr_bg;
  logic              raw_q, raw_n;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] value_view;

  assign idx   = addr[ADDR_W-1:2];
  assign valid = (addr[1:0] == 2'b00) && (idx < N_WORDS);
  assign sel   = valid ? word_e'(idx[2:0]) : W_NONE;

  assign wr_load = we && (sel == W_LOAD);
  assign wr_ctrl = we && (sel == W_CTRL);
  assign wr_clr  = we && (sel == W_CLR);
  assign wr_bg   = we && (sel == W_BGLOAD);

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_ctrl)
      ctrl_n = ctrl_t'(wdata[7:0]);
    else if (expire && ctrl_q.oneshot)
      ctrl_n.enable = 1'b0;
  end

  assign limit_n      = (wr_load || wr_bg) ? wdata : limit_q;
  assign force_reload = wr_load || (wr_ctrl && ctrl_n.enable);
  assign restart_ps   = wr_ctrl;
  assign raw_n        = expire ? 1'b1 : (wr_clr ? 1'b0 : raw_q);

  assign value_view = ctrl_q.wide ? count_q : {{(DATA_W-16){1'b0}}, count_q[15:0]};

  always_comb begin
    unique case (sel)
      W_LOAD, W_BGLOAD: rd_mux = limit_q;
      W_VALUE:          rd_mux = value_view;
      W_CTRL:           rd_mux = {{(DATA_W-8){1'b0}}, ctrl_q};
      W_RAW:            rd_mux = {{(DATA_W-1){1'b0}}, raw_q};
      W_MIS:            rd_mux = {{(DATA_W-1){1'b0}}, raw_q & ctrl_q.ie};
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RESET;
      limit_q <= '0;
      raw_q   <= 1'b0;
      irq     <= 1'b0;
      rdata   <= '0;
    end else begin
      ctrl_q  <= ctrl_n;
      limit_q <= limit_n;
      raw_q   <= raw_n;
      irq     <= raw_n & ctrl_n.ie;
      rdata   <= rd_mux;
    end
  end

  // R10: raw flag is sticky until a clear write
  p_raw_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (raw_q && !wr_clr) |=> raw_q);

  // R8: one-shot expiry drops the enable bit unless control is rewritten
  p_oneshot_halt_r8: assert property (@(posedge clk) disable iff (rst)
    (expire && ctrl_q.oneshot && !wr_ctrl) |=> !ctrl_q.enable);

  // R7: 16-bit mode reads the count with zero upper half
  p_value_hi_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (sel == W_VALUE && !ctrl_q.wide) |=> (rdata[31:16] == 16'h0));

  // R11: interrupt output never high while enable bit is clear
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.ie |-> !irq);

endmodule

// File: rtl/dctimer_core.sv
module dctimer_core
  import dct_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int PS_SHIFT_MID = 4,
  parameter int PS_SHIFT_MAX = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  ctrl_t             ctrl_q, ctrl_n;
  logic [DATA_W-1:0] limit_q, limit_n, count_q;
  logic              force_reload, restart_ps, expire, ptick;

  dct_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .we           (we),
    .addr         (addr),
    .wdata        (wdata),
    .expire       (expire),
    .count_q      (count_q),
    .ctrl_q       (ctrl_q),
    .ctrl_n       (ctrl_n),
    .limit_q      (limit_q),
    .limit_n      (limit_n),
    .force_reload (force_reload),
    .restart_ps   (restart_ps),
    .rdata        (rdata),
    .irq          (irq)
  );

  dct_prescaler #(.SH_MID(PS_SHIFT_MID), .SH_MAX(PS_SHIFT_MAX)) u_ps (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .sel     (ctrl_q.presc),
    .restart (restart_ps),
    .ptick   (ptick)
  );

  dct_counter u_cnt (
    .clk          (clk),
    .rst          (rst),
    .ptick        (ptick),
    .ctrl_q       (ctrl_q),
    .limit_q      (limit_q),
    .ctrl_n       (ctrl_n),
    .limit_n      (limit_n),
    .force_reload (force_reload),
    .count_q      (count_q),
    .expire       (expire)
  );

endmodule

// File: tb/sim_dctimer_core.sv
module sim_dctimer_core;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b1;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  dctimer_core u0 (
    .clk(clk), .rst(rst), .tick(tick), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc == WD_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, got cycle %0d exp below %0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h exp 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_irq(int lim);
    int n = 0;
    while (!irq && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Stop timer, clear flag, program reload, start with control c; returns start cycle.
  task automatic start(logic [31:0] lim, logic [7:0] c, output int c0);
    wr(8'h08, 32'h20);
    wr(8'h0C, 32'h0);
    wr(8'h00, lim);
    wr(8'h08, {24'h0, c});
    c0 = cyc;
  endtask

  task automatic run_periodic(int ps, int lim, int div);
    int c0, c1;
    start(lim, 8'hE2 | 8'(ps << 2), c0);
    wait_irq(4000);
    c1 = cyc;
    chk($sformatf("R3 R9 first expiry ps=%0d L=%0d", ps, lim), c1 - c0, lim * div);
    wr(8'h0C, 32'h0);
    chk("R10 clear drops irq", {31'h0, irq}, 32'h0);
    wait_irq(4000);
    chk($sformatf("R4 period ps=%0d L=%0d", ps, lim), cyc - c1, (lim + 1) * div);
  endtask

  initial begin
    logic [31:0] d;
    int c0, c1;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq low", {31'h0, irq}, 32'h0);
    rd(8'h08, d); chk("R1 control", d, 32'h20);
    rd(8'h04, d); chk("R1 value", d, 32'h0);
    rd(8'h00, d); chk("R1 load", d, 32'h0);

    // R3 R4 R9 periodic sweep at divide-by-1 and divide-by-16
    for (int ps = 0; ps < 2; ps++)
      for (int lim = 1; lim <= 6; lim++)
        run_periodic(ps, lim, (ps == 0) ? 1 : 16);
    run_periodic(2, 2, 256);
    run_periodic(3, 4, 1);

    // R9 tick gating
    tick = 1'b0;
    start(32'd5, 8'hE2, c0);
    idle(20);
    rd(8'h04, d); chk("R9 no count without tick", d, 32'd5);
    tick = 1'b1;
    c1 = cyc;
    wait_irq(100);
    chk("R9 count resumes with tick", cyc - c1, 5);

    // R6 R7 free-running 16-bit
    start(32'h1234, 8'hA0, c0);
    rd(8'h04, d); chk("R6 free16 reload", d, 32'hFFFF - (cyc - c0 - 1));
    idle(100);
    rd(8'h04, d); chk("R7 free16 count", d, 32'hFFFF - (cyc - c0 - 1));

    // R6 free-running 32-bit
    start(32'h1234, 8'hA2, c0);
    idle(37);
    rd(8'h04, d); chk("R6 free32 count", d, 32'hFFFFFFFF - 32'(cyc - c0 - 1));

    // R7 16-bit periodic truncates reload value
    start(32'h00012345, 8'hE0, c0);
    rd(8'h04, d); chk("R7 truncated reload", d, 32'h2345);
    start(32'h00010003, 8'hE0, c0);
    wait_irq(100);
    chk("R7 16-bit expiry", cyc - c0, 3);

    // R8 one-shot
    start(32'd4, 8'hA3, c0);
    wait_irq(100);
    chk("R8 one-shot expiry", cyc - c0, 4);
    idle(10);
    rd(8'h04, d); chk("R8 stopped at zero", d, 32'h0);
    rd(8'h08, d); chk("R8 enable cleared", d, 32'h23);
    chk("R8 irq held", {31'h0, irq}, 32'h1);

    // R5 background load
    start(32'd5, 8'hE2, c0);
    wr(8'h18, 32'd9);
    rd(8'h04, d); chk("R5 count not restarted", d, 32'(5 - (cyc - c0 - 1)));
    rd(8'h00, d); chk("R2 load offset reads limit", d, 32'd9);
    rd(8'h18, d); chk("R2 bg offset reads limit", d, 32'd9);
    wait_irq(100);
    c1 = cyc;
    chk("R5 first expiry on old value", c1 - c0, 5);
    wr(8'h0C, 32'h0);
    wait_irq(100);
    chk("R5 next period uses new value", cyc - c1, 10);

    // R3 load write on running timer reloads now
    start(32'd100, 8'hE2, c0);
    idle(10);
    wr(8'h00, 32'd7);
    c1 = cyc;
    wait_irq(200);
    chk("R3 load reloads immediately", cyc - c1, 7);

    // R12 control rewrite restarts period
    start(32'd50, 8'hE2, c0);
    idle(10);
    wr(8'h08, 32'hE2);
    c1 = cyc;
    wait_irq(200);
    chk("R12 control write reload", cyc - c1, 50);

    // R11 masking
    wr(8'h08, 32'h00);
    wr(8'h0C, 32'h0);
    wr(8'h00, 32'd3);
    wr(8'h08, 32'hC2);
    idle(5);
    chk("R11 irq masked", {31'h0, irq}, 32'h0);
    rd(8'h10, d); chk("R11 raw set while masked", d, 32'h1);
    rd(8'h14, d); chk("R11 masked status zero", d, 32'h0);
    wr(8'h08, 32'hE2);
    chk("R11 irq on enable", {31'h0, irq}, 32'h1);
    rd(8'h14, d); chk("R11 masked status one", d, 32'h1);

    // R10 clear colliding with expiry
    start(32'd3, 8'hE2, c0);
    idle(2);
    wr(8'h0C, 32'h0);
    chk("R10 set wins over clear", {31'h0, irq}, 32'h1);
    rd(8'h10, d); chk("R10 raw after collision", d, 32'h1);

    // R2 ignored and undefined locations
    wr(8'h08, 32'h20);
    wr(8'h00, 32'h55);
    wr(8'h04, 32'hDEAD);
    rd(8'h04, d); chk("R2 value write ignored", d, 32'hFFFF);
    wr(8'h1C, 32'hFFFFFFFF);
    wr(8'h40, 32'hFF);
    wr(8'h09, 32'hFF);
    rd(8'h1C, d); chk("R2 undefined reads zero", d, 32'h0);
    rd(8'h40, d); chk("R2 out of range reads zero", d, 32'h0);
    rd(8'h00, d); chk("R2 load untouched", d, 32'h55);
    rd(8'h08, d); chk("R2 control untouched", d, 32'h20);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule